// File: doc/BRIEF.md
# I2C Master Event Status and Interrupt Vector Unit

This unit collects the event flags of an I2C master controller into one 16-bit status word and turns them into a level interrupt and two DMA request lines. Transfer logic elsewhere sends one-cycle set pulses for events such as a NACK or a ready buffer. It also sends clear pulses for flags that only hardware may drop, and it supplies a bus-busy level. The host reaches the unit through a simple register port. A write or read strobe with a 3-bit register select is sampled on the clock edge, and read data is registered and valid in the cycle after the strobe.

The host can work in two ways. It can poll the status word and clear flags by writing ones. It can also read the vector register, which names the lowest-numbered pending enabled event and acknowledges it in the same access. Each ready flag can instead be served by DMA. Switching DMA on for a direction removes that flag's interrupt enable, so the interrupt and the DMA request never compete for the same event. A self-test write raises all six low event flags at once so that the interrupt path can be exercised.

Register selects: 0 status, 1 enable mask, 2 vector, 3 DMA config, 4 self-test (write-only, reads 0). Any other select reads 0.

Top module: `evt_irq_hub`

## Requirements
- R1: `irq` is high exactly when the stored status ANDed with the enable mask, as held in the previous cycle, is non-zero.
- R2: A read of select 2 returns the index plus one of the lowest set bit of (status AND mask), or 0 if none is set. The same access clears that status bit.
- R3: A read of select 0 returns the stored flags with the `bus_busy` level placed in bit 12. Bit 12 is never stored.
- R4: A write to select 0 clears only those status bits that are set both in the written value and in 0x0027. The ready flags (bit 3 receive, bit 4 transmit) are dropped only by `hw_clr`.
- R5: `dma_rx_req` follows status bit 3 while DMA-config bit 15 is set and `dma_tx_req` follows status bit 4 while DMA-config bit 7 is set. Each is low while its enable is clear. Only bits 15 and 7 of the DMA config are stored and read back.
- R6: A write to select 3 with bit 15 set clears enable bit 3, and one with bit 7 set clears enable bit 4. Other enable bits are kept.
- R7: A write to select 1 stores bits 5:0 of the value, or only bits 4:0 when the `NEW_REV` parameter is 0. Reading select 1 returns the stored mask.
- R8: A write to select 4 with bit 11 set forces status bits 5:0 to one.
- R9: When a set pulse and any clear (host write, vector acknowledge or `hw_clr`) hit the same status bit in one cycle, the bit ends up set.
- R10: `irq`, `dma_rx_req` and `dma_tx_req` are registered. They change one clock after the status or mask change that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Host write strobe |
| reg_rd | input | 1 | Host read strobe |
| reg_addr | input | ADDR_W | Register select |
| reg_wdata | input | DATA_W | Host write data |
| reg_rdata | output | DATA_W | Registered read data, valid the cycle after `reg_rd` |
| evt_set | input | DATA_W | One-cycle set pulses from transfer logic |
| hw_clr | input | DATA_W | One-cycle hardware clear pulses |
| bus_busy | input | 1 | Bus-busy level reported in status bit 12 |
| irq | output | 1 | Level interrupt |
| dma_rx_req | output | 1 | Receive DMA request |
| dma_tx_req | output | 1 | Transmit DMA request |

## Verification
The bench builds two copies of the unit. The main copy uses the default parameters (16-bit status, six enable bits). A second copy, with `NEW_REV` set to 0, shares the same stimulus so that the narrower five-bit enable mask can be read back and compared with the full one. With 16-bit status and six enable bits, the random traffic can reach every vector value from 0 to 6. It also reaches both DMA directions and the cases where a set pulse and a clear collide on one bit.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

   typedef enum logic [2:0] {
      SEL_STAT = 3'd0,
      SEL_EN   = 3'd1,
      SEL_VEC  = 3'd2,
      SEL_DMA  = 3'd3,
      SEL_TEST = 3'd4
   } reg_sel_e;

   localparam int SEL_BITS = 3;

endpackage

// File: rtl/evt_status_reg.sv
module evt_status_reg #(
   parameter int DATA_W = 16,
   parameter logic [DATA_W-1:0] STORE_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_vec,
   input  logic [DATA_W-1:0] clr_vec,
   output logic [DATA_W-1:0] stat_q
);

   logic [DATA_W-1:0] stat_d;

   // set is applied after clear so a colliding set survives
   always_comb begin
      stat_d = ((stat_q & ~clr_vec) | set_vec) & STORE_MASK;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stat_q <= '0;
      else        stat_q <= stat_d;
   end

endmodule

// File: rtl/evt_prio_vec.sv
module evt_prio_vec #(
   parameter int DATA_W = 16,
   localparam int VEC_W = $clog2(DATA_W + 1)
) (
   input  logic [DATA_W-1:0] pend,
   output logic [DATA_W-1:0] first_hot,
   output logic [VEC_W-1:0]  vec_idx
);

   logic [DATA_W-1:0] lower_any;

   assign lower_any[0] = 1'b0;

   genvar gi;
   generate
      for (gi = 1; gi < DATA_W; gi++) begin : g_chain
         assign lower_any[gi] = lower_any[gi-1] | pend[gi-1];
      end
   endgenerate

   assign first_hot = pend & ~lower_any;

   always_comb begin
      vec_idx = '0;
      for (int i = 0; i < DATA_W; i++) begin
         if (first_hot[i]) vec_idx = vec_idx | VEC_W'(i + 1);
      end
   end

endmodule

// File: rtl/evt_out_stage.sv
module evt_out_stage #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] pend,
   input  logic              rx_rdy,
   input  logic              tx_rdy,
   input  logic              rx_dma_en,
   input  logic              tx_dma_en,
   output logic              irq,
   output logic              dma_rx_req,
   output logic              dma_tx_req
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq        <= 1'b0;
         dma_rx_req <= 1'b0;
         dma_tx_req <= 1'b0;
      end else begin
         irq        <= |pend;
         dma_rx_req <= rx_dma_en & rx_rdy;
         dma_tx_req <= tx_dma_en & tx_rdy;
      end
   end

endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
   import evt_irq_pkg::*;
#(
   parameter int DATA_W        = 16,
   parameter int ADDR_W        = 3,
   parameter bit NEW_REV       = 1'b1,
   parameter int EN_W_NEW      = 6,
   parameter int EN_W_OLD      = 5,
   parameter int BUSY_BIT      = 12,
   parameter int RX_RDY_BIT    = 3,
   parameter int TX_RDY_BIT    = 4,
   parameter int RX_DMA_EN_BIT = 15,
   parameter int TX_DMA_EN_BIT = 7,
   parameter int SELFTEST_BIT  = 11,
   parameter int FORCE_CNT     = 6,
   parameter logic [DATA_W-1:0] HOST_CLR_MASK = DATA_W'(16'h0027)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [DATA_W-1:0] evt_set,
   input  logic [DATA_W-1:0] hw_clr,
   input  logic              bus_busy,
   output logic              irq,
   output logic              dma_rx_req,
   output logic              dma_tx_req
);

   localparam int VEC_W = $clog2(DATA_W + 1);
   localparam logic [DATA_W-1:0] ONE        = DATA_W'(1);
   localparam logic [DATA_W-1:0] STORE_MASK = ~(ONE << BUSY_BIT);
   localparam logic [DATA_W-1:0] FORCE_MASK = (ONE << FORCE_CNT) - ONE;
   localparam logic [DATA_W-1:0] DMA_KEEP   = (ONE << RX_DMA_EN_BIT) | (ONE << TX_DMA_EN_BIT);
   localparam logic [DATA_W-1:0] RDY_BITS   = (ONE << RX_RDY_BIT) | (ONE << TX_RDY_BIT);

   // elaboration checks
   if (DATA_W < 16) begin : g_chk_w
      $error("evt_irq_hub: DATA_W must be at least 16");
   end
   if (ADDR_W < SEL_BITS) begin : g_chk_a
      $error("evt_irq_hub: ADDR_W too small for the register selects");
   end
   if ((HOST_CLR_MASK & RDY_BITS) != '0) begin : g_chk_clr
      $error("evt_irq_hub: host clear mask must not cover ready flags");
   end
   if (EN_W_NEW > DATA_W || EN_W_OLD > EN_W_NEW) begin : g_chk_en
      $error("evt_irq_hub: enable widths out of range");
   end
   if (FORCE_CNT > DATA_W || BUSY_BIT >= DATA_W) begin : g_chk_bits
      $error("evt_irq_hub: bit positions out of range");
   end

   // enable-mask width chosen by revision
   logic [DATA_W-1:0] en_keep;
   generate
      if (NEW_REV) begin : g_rev_new
         assign en_keep = (ONE << EN_W_NEW) - ONE;
      end else begin : g_rev_old
         assign en_keep = (ONE << EN_W_OLD) - ONE;
      end
   endgenerate

   // register decode
   logic wr_stat, wr_en, wr_dma, wr_test;
   logic rd_vec;
   assign wr_stat = reg_wr && (reg_addr == ADDR_W'(SEL_STAT));
   assign wr_en   = reg_wr && (reg_addr == ADDR_W'(SEL_EN));
   assign wr_dma  = reg_wr && (reg_addr == ADDR_W'(SEL_DMA));
   assign wr_test = reg_wr && (reg_addr == ADDR_W'(SEL_TEST));
   assign rd_vec  = reg_rd && (reg_addr == ADDR_W'(SEL_VEC));

   logic [DATA_W-1:0] stat_q;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] dma_q;
   logic [DATA_W-1:0] pend;
   logic [DATA_W-1:0] first_hot;
   logic [VEC_W-1:0]  vec_idx;
   logic [DATA_W-1:0] set_vec;
   logic [DATA_W-1:0] clr_vec;

   assign pend = stat_q & mask_q;

   evt_prio_vec #(.DATA_W(DATA_W)) u_prio (
      .pend      (pend),
      .first_hot (first_hot),
      .vec_idx   (vec_idx)
   );

   always_comb begin
      clr_vec = hw_clr;
      if (wr_stat) clr_vec = clr_vec | (reg_wdata & HOST_CLR_MASK);
      if (rd_vec)  clr_vec = clr_vec | first_hot;
      set_vec = evt_set;
      if (wr_test && reg_wdata[SELFTEST_BIT]) set_vec = set_vec | FORCE_MASK;
   end

   evt_status_reg #(.DATA_W(DATA_W), .STORE_MASK(STORE_MASK)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .stat_q  (stat_q)
   );

   // enable mask and DMA config
   logic [DATA_W-1:0] en_drop;
   always_comb begin
      en_drop = '0;
      if (reg_wdata[RX_DMA_EN_BIT]) en_drop = en_drop | (ONE << RX_RDY_BIT);
      if (reg_wdata[TX_DMA_EN_BIT]) en_drop = en_drop | (ONE << TX_RDY_BIT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '0;
         dma_q  <= '0;
      end else begin
         if (wr_en) begin
            mask_q <= reg_wdata & en_keep;
         end else if (wr_dma) begin
            mask_q <= mask_q & ~en_drop;
         end
         if (wr_dma) dma_q <= reg_wdata & DMA_KEEP;
      end
   end

   // read data
   logic [DATA_W-1:0] rd_mux;
   always_comb begin
      unique case (reg_addr)
         ADDR_W'(SEL_STAT): rd_mux = stat_q | (DATA_W'(bus_busy) << BUSY_BIT);
         ADDR_W'(SEL_EN):   rd_mux = mask_q;
         ADDR_W'(SEL_VEC):  rd_mux = DATA_W'(vec_idx);
         ADDR_W'(SEL_DMA):  rd_mux = dma_q;
         default:           rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      reg_rdata <= '0;
      else if (reg_rd) reg_rdata <= rd_mux;
   end

   evt_out_stage #(.DATA_W(DATA_W)) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .pend       (pend),
      .rx_rdy     (stat_q[RX_RDY_BIT]),
      .tx_rdy     (stat_q[TX_RDY_BIT]),
      .rx_dma_en  (dma_q[RX_DMA_EN_BIT]),
      .tx_dma_en  (dma_q[TX_DMA_EN_BIT]),
      .irq        (irq),
      .dma_rx_req (dma_rx_req),
      .dma_tx_req (dma_tx_req)
   );

endmodule

// File: rtl/evt_irq_hub_chk.sv
module evt_irq_hub_chk
   import evt_irq_pkg::*;
#(
   parameter int DATA_W     = 16,
   parameter int ADDR_W     = 3,
   parameter int BUSY_BIT   = 12,
   parameter int RX_RDY_BIT = 3,
   parameter int FORCE_CNT  = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic              wd_rx_en,
   input logic              wd_test,
   input logic [DATA_W-1:0] evt_set,
   input logic              hw_clr_rx,
   input logic [DATA_W-1:0] stat_q,
   input logic [DATA_W-1:0] mask_q,
   input logic              dma_rx_en,
   input logic [DATA_W-1:0] reg_rdata,
   input logic              irq,
   input logic              dma_rx_req
);

   localparam logic [DATA_W-1:0] STORE = ~(DATA_W'(1) << BUSY_BIT);

   AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (irq == (|$past(stat_q & mask_q)))); // R1

   AST_VEC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'(SEL_VEC) && (|(stat_q & mask_q))) |=> (reg_rdata != '0)); // R2

   AST_VEC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'(SEL_VEC) && !(|(stat_q & mask_q))) |=> (reg_rdata == '0)); // R2

   AST_READY_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && !reg_rd && reg_addr == ADDR_W'(SEL_STAT) && stat_q[RX_RDY_BIT] && !hw_clr_rx)
      |=> stat_q[RX_RDY_BIT]); // R4

   AST_RX_DMA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      !dma_rx_en |=> !dma_rx_req); // R5

   AST_DMA_DROPS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(SEL_DMA) && wd_rx_en) |=> !mask_q[RX_RDY_BIT]); // R6

   AST_SELFTEST_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == ADDR_W'(SEL_TEST) && wd_test) |=> (&stat_q[FORCE_CNT-1:0])); // R8

   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_set) |=> ((stat_q & $past(evt_set & STORE)) == $past(evt_set & STORE))); // R9

endmodule

bind evt_irq_hub evt_irq_hub_chk #(
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .BUSY_BIT   (BUSY_BIT),
   .RX_RDY_BIT (RX_RDY_BIT),
   .FORCE_CNT  (FORCE_CNT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_wr     (reg_wr),
   .reg_rd     (reg_rd),
   .reg_addr   (reg_addr),
   .wd_rx_en   (reg_wdata[RX_DMA_EN_BIT]),
   .wd_test    (reg_wdata[SELFTEST_BIT]),
   .evt_set    (evt_set),
   .hw_clr_rx  (hw_clr[RX_RDY_BIT]),
   .stat_q     (stat_q),
   .mask_q     (mask_q),
   .dma_rx_en  (dma_q[RX_DMA_EN_BIT]),
   .reg_rdata  (reg_rdata),
   .irq        (irq),
   .dma_rx_req (dma_rx_req)
);

// File: tb/evt_irq_hub_test.sv
module evt_irq_hub_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0, rd = 1'b0, busy = 1'b0;
   logic [2:0]  addr = '0;
   logic [15:0] wdata = '0, setp = '0, clrp = '0;
   logic [15:0] rdata, rdata_old;
   logic        irq, rxq, txq, irq_old, rxq_old, txq_old;

   int nchk = 0, nerr = 0, ncyc = 0;

   // reference state
   logic [15:0] m_stat = '0, m_mask = '0, m_dma = '0;
   logic        e_irq, e_rx, e_tx;
   logic [15:0] e_rd;

   always #4 clk = ~clk;

   evt_irq_hub uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_rd(rd), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata), .evt_set(setp), .hw_clr(clrp),
      .bus_busy(busy), .irq(irq), .dma_rx_req(rxq), .dma_tx_req(txq)
   );

   evt_irq_hub #(.NEW_REV(1'b0)) uut_old (
      .clk(clk), .rst_n(rst_n), .reg_wr(wr), .reg_rd(rd), .reg_addr(addr),
      .reg_wdata(wdata), .reg_rdata(rdata_old), .evt_set(setp), .hw_clr(clrp),
      .bus_busy(busy), .irq(irq_old), .dma_rx_req(rxq_old), .dma_tx_req(txq_old)
   );

   function automatic logic [15:0] lowest(input logic [15:0] v);
      for (int i = 0; i < 16; i++) if (v[i]) return 16'(1) << i;
      return '0;
   endfunction

   function automatic logic [15:0] vec_of(input logic [15:0] v);
      for (int i = 0; i < 16; i++) if (v[i]) return 16'(i + 1);
      return '0;
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic summary;
      $display("  Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
   endtask

   // one host/event cycle, then compare outputs against the reference
   task automatic step(input logic w, input logic r, input logic [2:0] a,
                       input logic [15:0] d, input logic [15:0] s,
                       input logic [15:0] c, input logic b);
      logic [15:0] clr, setv, drop;
      wr = w; rd = r; addr = a; wdata = d; setp = s; clrp = c; busy = b;
      @(posedge clk);
      ncyc++;
      e_irq = |(m_stat & m_mask);                 // R1 R10: previous-cycle state
      e_rx  = m_dma[15] & m_stat[3];              // R5
      e_tx  = m_dma[7] & m_stat[4];
      case (a)
         3'd0:    e_rd = m_stat | (16'(b) << 12); // R3
         3'd1:    e_rd = m_mask;                  // R7
         3'd2:    e_rd = vec_of(m_stat & m_mask); // R2
         3'd3:    e_rd = m_dma;
         default: e_rd = '0;
      endcase
      clr = c;
      if (w && a == 3'd0) clr = clr | (d & 16'h0027); // R4
      if (r && a == 3'd2) clr = clr | lowest(m_stat & m_mask);
      setv = s;
      if (w && a == 3'd4 && d[11]) setv = setv | 16'h003f; // R8
      if (w && a == 3'd1) m_mask = d & 16'h003f;
      else if (w && a == 3'd3) begin              // R6
         drop = '0;
         if (d[15]) drop[3] = 1'b1;
         if (d[7])  drop[4] = 1'b1;
         m_mask = m_mask & ~drop;
      end
      if (w && a == 3'd3) m_dma = d & 16'h8080;
      m_stat = ((m_stat & ~clr) | setv) & 16'hefff; // R9: set after clear
      #1;
      wr = 1'b0; rd = 1'b0; setp = '0; clrp = '0;
      chk("R1 R10 irq", 16'(irq), 16'(e_irq));
      chk("R5 dma_rx_req", 16'(rxq), 16'(e_rx));
      chk("R5 dma_tx_req", 16'(txq), 16'(e_tx));
      if (r) chk("R2 R3 R7 read data", rdata, e_rd);
   endtask

   task automatic idle;
      step(1'b0, 1'b0, 3'd7, '0, '0, '0, busy);
   endtask

   initial begin
      #(8 * 150000);
      nerr++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
   end

   initial begin
      logic [15:0] v;
      logic [2:0]  a;
      int          op;
      void'($urandom(32'd4242));
      #20 rst_n = 1'b1;
      #3;
      // reset state
      chk("R1 reset irq", 16'(irq), 16'h0);
      chk("R5 reset dma", 16'({rxq, txq}), 16'h0);
      step(1'b0, 1'b1, 3'd0, '0, '0, '0, 1'b0);
      chk("R3 reset status", rdata, 16'h0000);

      // R10 latency: set event with enable, irq lags one clock
      step(1'b1, 1'b0, 3'd1, 16'h0002, '0, '0, 1'b0);
      step(1'b0, 1'b0, 3'd7, '0, 16'h0002, '0, 1'b0);
      chk("R10 irq not yet", 16'(irq), 16'h0);
      idle();
      chk("R10 irq raised", 16'(irq), 16'h1);
      step(1'b1, 1'b0, 3'd0, 16'h0002, '0, '0, 1'b0);
      idle();
      chk("R1 irq cleared", 16'(irq), 16'h0);

      // R2 vector order and acknowledge
      step(1'b1, 1'b0, 3'd1, 16'hffff, 16'h0024, '0, 1'b0);
      step(1'b0, 1'b1, 3'd2, '0, '0, '0, 1'b0);
      chk("R2 vector first", rdata, 16'd3);
      step(1'b0, 1'b1, 3'd2, '0, '0, '0, 1'b0);
      chk("R2 vector second", rdata, 16'd6);
      step(1'b0, 1'b1, 3'd2, '0, '0, '0, 1'b0);
      chk("R2 vector empty", rdata, 16'd0);

      // R3 busy bit
      step(1'b0, 1'b1, 3'd0, '0, '0, '0, 1'b1);
      chk("R3 busy in bit 12", rdata, 16'h1000);
      busy = 1'b0;

      // R4 host clear mask
      step(1'b0, 1'b0, 3'd7, '0, 16'h8c1b, '0, 1'b0);
      step(1'b1, 1'b0, 3'd0, 16'hffff, '0, '0, 1'b0);
      step(1'b0, 1'b1, 3'd0, '0, '0, '0, 1'b0);
      chk("R4 only 0x27 bits cleared", rdata, 16'h8c18);
      step(1'b0, 1'b0, 3'd7, '0, '0, 16'hffff, 1'b0);

      // R9 set wins over host clear
      step(1'b1, 1'b0, 3'd0, 16'h0002, 16'h0002, '0, 1'b0);
      step(1'b0, 1'b1, 3'd0, '0, '0, '0, 1'b0);
      chk("R9 set beats clear", rdata, 16'h0002);

      // R6 DMA drops enables
      step(1'b1, 1'b0, 3'd1, 16'h003f, '0, '0, 1'b0);
      step(1'b0, 1'b1, 3'd1, '0, '0, '0, 1'b0);
      chk("R7 new mask width", rdata, 16'h003f);
      chk("R7 old mask width", rdata_old, 16'h001f);
      step(1'b1, 1'b0, 3'd3, 16'hffff, '0, '0, 1'b0);
      step(1'b0, 1'b1, 3'd1, '0, '0, '0, 1'b0);
      chk("R6 enables dropped", rdata, 16'h0027);
      step(1'b0, 1'b1, 3'd3, '0, '0, '0, 1'b0);
      chk("R5 dma config stored bits", rdata, 16'h8080);

      // R5 DMA mirroring
      step(1'b0, 1'b0, 3'd7, '0, 16'h0018, '0, 1'b0);
      idle();
      chk("R5 rx request", 16'(rxq), 16'h1);
      chk("R5 tx request", 16'(txq), 16'h1);
      step(1'b1, 1'b0, 3'd3, 16'h0000, '0, '0, 1'b0);
      idle();
      chk("R5 rx gated off", 16'(rxq), 16'h0);

      // R8 self-test
      step(1'b0, 1'b0, 3'd7, '0, '0, 16'hffff, 1'b0);
      step(1'b1, 1'b0, 3'd4, 16'h0800, '0, '0, 1'b0);
      step(1'b0, 1'b1, 3'd0, '0, '0, '0, 1'b0);
      chk("R8 self-test forces", rdata, 16'h003f);
      step(1'b0, 1'b1, 3'd4, '0, '0, '0, 1'b0);
      chk("R8 self-test reads zero", rdata, 16'h0000);

      // constrained random traffic
      for (int n = 0; n < 4000; n++) begin
         op = int'($urandom_range(0, 9));
         a  = 3'($urandom_range(0, 5));
         v  = 16'($urandom);
         if (op < 3)
            step(1'b1, 1'b0, a, v, 16'($urandom & $urandom & $urandom),
                 16'($urandom & $urandom & $urandom), 1'($urandom));
         else if (op < 7)
            step(1'b0, 1'b1, a, '0, 16'($urandom & $urandom & $urandom),
                 16'($urandom & $urandom & $urandom), 1'($urandom));
         else
            step(1'b0, 1'b0, 3'd7, '0, 16'($urandom & $urandom),
                 16'($urandom & $urandom & $urandom), 1'($urandom));
      end
      summary();
   end

endmodule